// File: doc/BRIEF.md
# Decoupled Fetch and Execute Pipeline

This block is a cycle-level timing skeleton of a processor core. A four-stage fetch pipe produces instruction words in address order: address generation, fetch cycle one, fetch cycle two, early decode. Early decode writes each word into an eight-entry instruction buffer. A two-stage execute pipe reads from that buffer. Its decode stage always takes one cycle. Its execute stage takes as many cycles as the latency field of the word asks for. The two pipes stall independently of each other, and the buffer is the only thing that links them.

Both pipes use a single memory port. The execute side can issue a data access on it, and that access always goes before a fetch. The address generator has four transitions. It holds its address while the pipe downstream is stalled. A redirect loads a target. A stop command parks it. With no command it steps forward by four. A redirect also clears every fetch stage and the buffer in the same cycle. When an instruction leaves the execute stage, the block emits a one-cycle retire pulse with the address of that instruction, so a testbench can measure how many cycles each instruction took.

Top module: `dfe_pipe`

## Requirements
- R1: After reset the address generator is stopped, so there is no memory request and no retire pulse until the first redirect.
- R2: A redirect loads its target into address generation in the next cycle. Starting from empty pipes, with latency 1 and the port always ready, the retire pulse of the target appears 6 cycles after the clock edge that samples the redirect.
- R3: With no command the fetch address steps by 4 each time address generation hands on. With latency 1 and the port always ready, one instruction retires per cycle, with addresses ascending by 4.
- R4: Bits [3:0] of a word give the number of cycles it spends in the execute stage, and 0 counts as 1. Decode waits behind it. While decode is occupied, the spacing between two consecutive retires equals the latency of the later instruction.
- R5: The buffer holds 8 words. When it is full, the fetch stages hold their contents. While the execute stage is blocked, exactly 12 fetches are accepted: one each for execute and decode, eight for the buffer, one for early decode and one for fetch cycle two.
- R6: A stall in either pipe never skips or repeats an instruction address.
- R7: Bit 4 of a word requests an execute-side access at the address in bits [8+AW-1:8]. On such a request `mem_src_o` is 1, and the request wins the port over any fetch in the same cycle. The instruction retires in the cycle its access is accepted.
- R8: While `mem_ready_i` is 0, no access completes, and both the fetch stage and the execute stage hold.
- R9: A redirect clears the fetch stages and the buffer, and no buffer entry is read in that cycle. Only instructions already in decode or execute retire before the target stream.
- R10: A stop command parks the address generator, and no new addresses enter the fetch pipe until a redirect. A redirect in the same cycle as a stop takes priority.
- R11: Each instruction produces exactly one `retire_o` pulse lasting one cycle, and `retire_addr_o` carries its fetch address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redirect_i | input | 1 | Load a new fetch target and flush the fetch side |
| redirect_addr_i | input | AW | Redirect target address |
| stop_i | input | 1 | Park the address generator |
| mem_req_o | output | 1 | Memory request valid |
| mem_src_o | output | 1 | 1: execute-side access, 0: instruction fetch |
| mem_addr_o | output | AW | Memory request address |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_rdata_i | input | IW | Instruction word for a fetch, same cycle |
| retire_o | output | 1 | An instruction leaves the execute stage |
| retire_addr_o | output | AW | Address of the retiring instruction |

## Verification
Two pairs of events can fall in the same cycle. An execute-side access can collide with a pending fetch on the shared port, and a redirect can coincide with both a buffer write and a buffer read. The first pair is provoked by running a stream in which every fourth word asks for a data access while the ready signal drops every third cycle. Each such retire must then coincide with an accepted execute request at the expected address, and the fetched stream must stay gapless. The second pair is provoked by redirecting a saturated stream with latency 1. Exactly one older instruction may retire, and the target must follow exactly six cycles after the redirect edge.

// File: rtl/dfe_pkg.sv
package dfe_pkg;
  localparam int LAT_W     = 4;
  localparam int MEM_BIT   = 4;
  localparam int XADDR_LSB = 8;
  localparam int INSN_STEP = 4;

  // cycles an instruction spends in execute; a zero field means one cycle
  function automatic logic [LAT_W-1:0] lat_eff(input logic [LAT_W-1:0] f);
    return (f == '0) ? LAT_W'(1) : f;
  endfunction
endpackage

// File: rtl/dfe_fetch.sv
module dfe_fetch #(
  parameter int AW = 16,
  parameter int IW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redirect,
  input  logic [AW-1:0] redirect_addr,
  input  logic          stop,
  input  logic          fetch_grant,
  input  logic [IW-1:0] mem_rdata,
  input  logic          out_ready,
  output logic          fetch_want,
  output logic [AW-1:0] fetch_addr,
  output logic          ied_valid,
  output logic [AW-1:0] ied_addr,
  output logic [IW-1:0] ied_word,
  output logic          iag_valid,
  output logic [AW-1:0] iag_addr
);
  import dfe_pkg::*;

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return a + AW'(INSN_STEP);
  endfunction

  logic          ic1_v, ic2_v;
  logic [AW-1:0] ic1_addr, ic2_addr;
  logic [IW-1:0] ic2_word;
  logic          ied_free, ic2_free, ic1_free, iag_move;

  assign ied_free   = !ied_valid || out_ready;
  assign ic2_free   = !ic2_v || ied_free;
  assign fetch_want = ic1_v && ic2_free;
  assign fetch_addr = ic1_addr;
  assign ic1_free   = !ic1_v || fetch_grant;
  assign iag_move   = iag_valid && ic1_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iag_valid <= 1'b0;
      iag_addr  <= '0;
      ic1_v     <= 1'b0;
      ic1_addr  <= '0;
      ic2_v     <= 1'b0;
      ic2_addr  <= '0;
      ic2_word  <= '0;
      ied_valid <= 1'b0;
      ied_addr  <= '0;
      ied_word  <= '0;
    end else if (redirect) begin
      // set transition: flush fetch stages, start from the target
      iag_valid <= 1'b1;
      iag_addr  <= redirect_addr;
      ic1_v     <= 1'b0;
      ic2_v     <= 1'b0;
      ied_valid <= 1'b0;
    end else begin
      if (ied_free) begin
        ied_valid <= ic2_v;
        ied_addr  <= ic2_addr;
        ied_word  <= ic2_word;
      end
      if (ic2_free) begin
        ic2_v <= fetch_grant;
        if (fetch_grant) begin
          ic2_addr <= ic1_addr;
          ic2_word <= mem_rdata;
        end
      end
      if (ic1_free) begin
        ic1_v    <= iag_valid;
        ic1_addr <= iag_addr;
      end
      // stop parks the unit; otherwise advance or wait
      if (stop) iag_valid <= 1'b0;
      else if (iag_move) iag_addr <= step_addr(iag_addr);
    end
  end
endmodule

// File: rtl/dfe_fifo.sv
module dfe_fifo #(
  parameter int W     = 48,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic                         pop,
  input  logic [W-1:0]                 wdata,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   cnt,
  output logic                         full,
  output logic                         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
  endfunction

  logic [W-1:0]     store_q [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;

  assign rdata = store_q[rptr];
  assign full  = (cnt == CNT_W'(DEPTH));
  assign empty = (cnt == '0);

  always_ff @(posedge clk) begin
    if (push) store_q[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= ptr_inc(wptr);
      if (pop)  rptr <= ptr_inc(rptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/dfe_exec.sv
module dfe_exec #(
  parameter int AW = 16,
  parameter int IW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] in_addr,
  input  logic [IW-1:0] in_word,
  input  logic          exec_ack,
  output logic          take,
  output logic          exec_req,
  output logic [AW-1:0] exec_addr,
  output logic          retire,
  output logic [AW-1:0] retire_addr
);
  import dfe_pkg::*;

  logic             dec_v, ex_v, ex_pend;
  logic [AW-1:0]    dec_addr, ex_addr;
  logic [IW-1:0]    dec_word, ex_word;
  logic [LAT_W-1:0] ex_cnt, ex_lat;
  logic             cnt_ok, ex_done, ex_free, dec_free;

  assign ex_lat      = lat_eff(ex_word[LAT_W-1:0]);
  assign cnt_ok      = (ex_cnt >= ex_lat);
  assign exec_req    = ex_v && ex_pend;
  assign exec_addr   = ex_word[XADDR_LSB +: AW];
  assign ex_done     = ex_v && cnt_ok && (!ex_pend || exec_ack);
  assign ex_free     = !ex_v || ex_done;
  assign dec_free    = !dec_v || ex_free;
  assign take        = in_valid && dec_free;
  assign retire      = ex_done;
  assign retire_addr = ex_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_v    <= 1'b0;
      dec_addr <= '0;
      dec_word <= '0;
      ex_v     <= 1'b0;
      ex_addr  <= '0;
      ex_word  <= '0;
      ex_cnt   <= '0;
      ex_pend  <= 1'b0;
    end else begin
      if (dec_free) begin
        dec_v    <= take;
        dec_addr <= in_addr;
        dec_word <= in_word;
      end
      if (ex_free) begin
        ex_v    <= dec_v;
        ex_addr <= dec_addr;
        ex_word <= dec_word;
        ex_cnt  <= LAT_W'(1);
        ex_pend <= dec_v && dec_word[MEM_BIT];
      end else begin
        if (!cnt_ok) ex_cnt <= ex_cnt + LAT_W'(1);
        if (exec_ack) ex_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dfe_pipe.sv
module dfe_pipe #(
  parameter int AW    = 16,
  parameter int IW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redirect_i,
  input  logic [AW-1:0] redirect_addr_i,
  input  logic          stop_i,
  output logic          mem_req_o,
  output logic          mem_src_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_ready_i,
  input  logic [IW-1:0] mem_rdata_i,
  output logic          retire_o,
  output logic [AW-1:0] retire_addr_o
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int EW    = AW + IW;

  logic          fetch_want, fetch_grant, exec_req, exec_ack;
  logic [AW-1:0] fetch_addr, exec_addr, iag_addr;
  logic          iag_valid, ied_valid, push, pop;
  logic [AW-1:0] ied_addr;
  logic [IW-1:0] ied_word;
  logic [EW-1:0] buf_rdata;
  logic [CNT_W-1:0] fifo_cnt;
  logic          buf_full, buf_empty;

  // shared port: the execute side always wins
  assign exec_ack    = exec_req && mem_ready_i;
  assign fetch_grant = fetch_want && !exec_req && !redirect_i && mem_ready_i;
  assign mem_req_o   = exec_req || (fetch_want && !redirect_i);
  assign mem_src_o   = exec_req;
  assign mem_addr_o  = exec_req ? exec_addr : fetch_addr;

  assign push = ied_valid && !buf_full && !redirect_i;

  dfe_fetch #(.AW(AW), .IW(IW)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .redirect(redirect_i), .redirect_addr(redirect_addr_i), .stop(stop_i),
    .fetch_grant(fetch_grant), .mem_rdata(mem_rdata_i), .out_ready(!buf_full),
    .fetch_want(fetch_want), .fetch_addr(fetch_addr),
    .ied_valid(ied_valid), .ied_addr(ied_addr), .ied_word(ied_word),
    .iag_valid(iag_valid), .iag_addr(iag_addr)
  );

  dfe_fifo #(.W(EW), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .flush(redirect_i),
    .push(push), .pop(pop), .wdata({ied_addr, ied_word}),
    .rdata(buf_rdata), .cnt(fifo_cnt), .full(buf_full), .empty(buf_empty)
  );

  dfe_exec #(.AW(AW), .IW(IW)) u_exec (
    .clk(clk), .rst_n(rst_n),
    .in_valid(!buf_empty && !redirect_i),
    .in_addr(buf_rdata[IW +: AW]), .in_word(buf_rdata[IW-1:0]),
    .exec_ack(exec_ack), .take(pop),
    .exec_req(exec_req), .exec_addr(exec_addr),
    .retire(retire_o), .retire_addr(retire_addr_o)
  );
endmodule

// File: rtl/dfe_pipe_chk.sv
module dfe_pipe_chk #(
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             redirect_i,
  input logic [AW-1:0]    redirect_addr_i,
  input logic             stop_i,
  input logic             mem_req_o,
  input logic [CNT_W-1:0] fifo_cnt,
  input logic             fetch_grant,
  input logic             exec_req,
  input logic             iag_valid,
  input logic [AW-1:0]    iag_addr
);
  // R5
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(DEPTH));

  // R7
  exec_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_req |-> (mem_req_o && !fetch_grant));

  // R9
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_i |=> (fifo_cnt == '0));

  // R2
  target_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_i |=> (iag_valid && iag_addr == $past(redirect_addr_i)));

  // R10
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !redirect_i) |=> !iag_valid);

  // R1
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!iag_valid && !redirect_i) |=> !iag_valid);
endmodule

bind dfe_pipe dfe_pipe_chk #(.AW(AW), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .redirect_i(redirect_i),
  .redirect_addr_i(redirect_addr_i), .stop_i(stop_i), .mem_req_o(mem_req_o),
  .fifo_cnt(fifo_cnt), .fetch_grant(fetch_grant), .exec_req(exec_req),
  .iag_valid(iag_valid), .iag_addr(iag_addr)
);

// File: tb/dfe_pipe_tb.sv
module dfe_pipe_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int IW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          redirect_i = 1'b0;
  logic [AW-1:0] redirect_addr_i = '0;
  logic          stop_i = 1'b0;
  logic          mem_req_o, mem_src_o, mem_ready_i, retire_o;
  logic [AW-1:0] mem_addr_o, retire_addr_o;
  logic [IW-1:0] mem_rdata_i;

  int vec = 0, miss = 0, cyc = 0;
  int lat_mode = 0, fix_lat = 1;
  bit mem_mode = 0, rdy = 1;
  int r_addr[512], r_cyc[512];
  bit r_xok[512];
  int n = 0, fgrant = 0, fg_first = -1, req_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // memory model: word layout [3:0] latency, [4] data access, [23:8] data address
  function automatic logic [IW-1:0] word_of(input logic [AW-1:0] a);
    logic [3:0] lat;
    logic mf;
    lat = (lat_mode == 0) ? 4'd1 : (lat_mode == 1) ? 4'(fix_lat) : {2'b00, a[3:2]};
    mf  = mem_mode && (a[3:2] == 2'b01);
    return {8'h00, a ^ 16'h5A5A, 3'b000, mf, lat};
  endfunction

  function automatic int eff_lat(input int a);
    logic [3:0] l;
    l = word_of(AW'(a)) & 4'hF;
    return (l == 0) ? 1 : int'(l);
  endfunction

  assign mem_rdata_i = word_of(mem_addr_o);
  assign mem_ready_i = rdy;

  dfe_pipe #(.AW(AW), .IW(IW), .DEPTH(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .redirect_i(redirect_i),
    .redirect_addr_i(redirect_addr_i), .stop_i(stop_i),
    .mem_req_o(mem_req_o), .mem_src_o(mem_src_o), .mem_addr_o(mem_addr_o),
    .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i),
    .retire_o(retire_o), .retire_addr_o(retire_addr_o)
  );

  // monitor, sampling away from the active edge
  always @(negedge clk) begin
    if (mem_req_o) req_cnt++;
    if (mem_req_o && !mem_src_o && mem_ready_i) fgrant++;
    if (retire_o && n < 512) begin
      if (n == 0) fg_first = fgrant;
      r_addr[n] = int'(retire_addr_o);
      r_cyc[n]  = cyc;
      r_xok[n]  = mem_req_o && mem_src_o && mem_ready_i &&
                  (mem_addr_o == (retire_addr_o ^ 16'h5A5A));
      n++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      miss++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int k);
    for (int i = 0; i < k; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic quiesce();
    step(1);
    stop_i = 1'b1;
    rdy = 1'b1;
    step(1);
    stop_i = 1'b0;
    step(250);
  endtask

  task automatic start(input int a, output int rd);
    n = 0; fgrant = 0; fg_first = -1;
    redirect_i = 1'b1;
    redirect_addr_i = AW'(a);
    step(1);
    redirect_i = 1'b0;
    rd = cyc;
  endtask

  task automatic seq_bad(input int from, input int upto, output int bad);
    bad = 0;
    for (int i = from; i < upto; i++)
      if (r_addr[i] != r_addr[i-1] + 4) bad++;
  endtask

  task automatic t_reset();
    int bad = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (mem_req_o || retire_o) bad++;
    end
    check(bad == 0, "R1 idle after reset", bad, 0);
  endtask

  task automatic t_fill();
    int rd, bad, badc;
    quiesce();
    lat_mode = 0; mem_mode = 0;
    start('h100, rd);
    step(30);
    check(n >= 20, "R3 retire count", n, 20);
    check(r_addr[0] == 'h100 && r_cyc[0] == rd + 6, "R2 first retire cycle", r_cyc[0] - rd, 6);
    seq_bad(1, 20, bad);
    check(bad == 0, "R11 retire addresses ascending", bad, 0);
    badc = 0;
    for (int i = 1; i < 20; i++) if (r_cyc[i] != r_cyc[i-1] + 1) badc++;
    check(badc == 0, "R3 one retire per cycle", badc, 0);
  endtask

  task automatic t_latency();
    int rd, bad, badg;
    quiesce();
    lat_mode = 2; mem_mode = 0;
    start('h200, rd);
    step(60);
    check(r_cyc[0] == rd + 6, "R4 first retire", r_cyc[0] - rd, 6);
    seq_bad(1, 20, bad);
    check(bad == 0, "R6 order with mixed latency", bad, 0);
    badg = 0;
    for (int i = 1; i < 20; i++)
      if (r_cyc[i] - r_cyc[i-1] != eff_lat(r_addr[i])) begin
        badg++;
        $display("FAIL R4 gap at 0x%0h: actual %0d expected %0d", r_addr[i],
                 r_cyc[i] - r_cyc[i-1], eff_lat(r_addr[i]));
      end
    check(badg == 0, "R4 retire spacing incl. zero field", badg, 0);
  endtask

  task automatic t_full();
    int rd, bad, badg;
    quiesce();
    lat_mode = 1; fix_lat = 15; mem_mode = 0;
    start('h300, rd);
    step(230);
    check(fg_first == 12, "R5 fetches before first retire", fg_first, 12);
    check(r_cyc[0] == rd + 20, "R4 latency 15 first retire", r_cyc[0] - rd, 20);
    check(n >= 14, "R5 progress after stall", n, 14);
    seq_bad(1, n, bad);
    check(bad == 0, "R6 no skip across full stall", bad, 0);
    badg = 0;
    for (int i = 1; i < n; i++) if (r_cyc[i] - r_cyc[i-1] != 15) badg++;
    check(badg == 0, "R4 spacing 15", badg, 0);
  endtask

  task automatic t_mem();
    int rd, bad, badx, nmem;
    quiesce();
    lat_mode = 0; mem_mode = 1;
    start('h400, rd);
    for (int k = 0; k < 60; k++) begin
      rdy = (k % 3 != 0);
      step(1);
    end
    rdy = 1'b1;
    step(40);
    check(n >= 30, "R8 progress with ready gaps", n, 30);
    seq_bad(1, n, bad);
    check(bad == 0, "R8 no skip under ready gaps", bad, 0);
    badx = 0; nmem = 0;
    for (int i = 0; i < n; i++)
      if (((r_addr[i] >> 2) & 3) == 1) begin
        nmem++;
        if (!r_xok[i]) badx++;
      end
    check(badx == 0 && nmem >= 5, "R7 data access wins port at retire", badx, 0);
  endtask

  task automatic t_redirect();
    int rd, rd2, j, bad;
    quiesce();
    lat_mode = 0; mem_mode = 0;
    start('h500, rd);
    step(15);
    redirect_i = 1'b1;
    redirect_addr_i = 16'h0800;
    step(1);
    redirect_i = 1'b0;
    rd2 = cyc;
    step(30);
    j = 0;
    while (j < n && r_cyc[j] < rd2) j++;
    check(j > 0 && j + 2 < n && r_addr[j] == r_addr[j-1] + 4 && r_cyc[j] == rd2,
          "R9 one older retire", r_addr[j], r_addr[j-1] + 4);
    check(r_addr[j+1] == 'h800, "R9 target follows", r_addr[j+1], 'h800);
    check(r_cyc[j+1] == rd2 + 6, "R9 target latency", r_cyc[j+1] - rd2, 6);
    seq_bad(j + 2, n, bad);
    check(bad == 0, "R9 target stream order", bad, 0);
  endtask

  task automatic t_stop();
    int rd, rq0, n0;
    quiesce();
    lat_mode = 0; mem_mode = 0;
    start('h600, rd);
    step(15);
    stop_i = 1'b1;
    step(1);
    stop_i = 1'b0;
    step(20);
    rq0 = req_cnt; n0 = n;
    step(20);
    check(req_cnt == rq0 && n == n0, "R10 parked after stop", req_cnt - rq0, 0);
    n = 0;
    stop_i = 1'b1;
    redirect_i = 1'b1;
    redirect_addr_i = 16'h0700;
    step(1);
    stop_i = 1'b0;
    redirect_i = 1'b0;
    rd = cyc;
    step(12);
    check(n > 0 && r_addr[0] == 'h700, "R10 redirect beats stop", r_addr[0], 'h700);
    check(r_cyc[0] == rd + 6, "R10 restart latency", r_cyc[0] - rd, 6);
  endtask

  initial begin
    step(4);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_latency();
    t_full();
    t_mem();
    t_redirect();
    t_stop();
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    wait (cyc > 60000);
    vec++;
    miss++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 60000);
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule